// File: doc/BRIEF.md
# Dual-Processor Ownership Lock and Doorbell

This block is a small register file shared by two processors. Each processor has its own word-wide register port, and the port index identifies which processor made the access. The block holds three things. The first is a hardware ownership lock. The second is a doorbell that interrupts the opposite processor. The third is a pair of 32-bit pending-request words, one per target processor, that software edits while it holds the lock.

A processor claims the lock by writing its tag to the lock register: 1 for processor 0, 2 for processor 1. It then reads back the owner field and compares it with its own tag. The owner gives the lock up by writing zero. Ringing the doorbell latches an interrupt on the other processor. That interrupt stays raised until the target acknowledges it. The doorbell and the lock do not affect each other.

The lock is a three-state machine:
- `LK_FREE` is the idle state. It moves to `LK_CPU0` when processor 0 writes tag 1, or when both processors write their tags in the same cycle. It moves to `LK_CPU1` when only processor 1 writes tag 2.
- `LK_CPU0` and `LK_CPU1` each return to `LK_FREE` only when their own holder writes zero. Every other write to the lock leaves them unchanged.

Each doorbell is a two-state machine:
- `BELL_IDLE` moves to `BELL_PEND` on a ring from the other processor.
- `BELL_PEND` moves back to `BELL_IDLE` on an acknowledge from its own processor, provided no new ring arrives in the same cycle.

Register word addresses: lock 0, ring 1, acknowledge/status 2, request word for processor 0 at 4, request word for processor 1 at 5.

Top module: `dual_cpu_lock_bell`

## Requirements
- R1: The lock register reads the owner in bits 1:0 (0 free, 1 processor 0, 2 processor 1). Bits 31:2 always read as zero.
- R2: While the lock is free, a write from processor c whose bits 1:0 equal c+1 makes c the owner, from the next cycle on.
- R3: While the lock is held, a tag write from the other processor leaves the owner unchanged.
- R4: A write of 0 in bits 1:0 from the owner frees the lock.
- R5: A write of 0 from a processor that is not the owner is ignored.
- R6: When both processors write their own tags in the same cycle while the lock is free, processor 0 becomes the owner.
- R7: A write with bit 0 set to the ring register (address 1) raises irq of the other processor. That irq stays high until it is acknowledged. The lock owner is unchanged by a ring.
- R8: A write with bit 0 set to address 2 by processor c clears irq[c]. A ring arriving in the same cycle wins over the clear. Reading address 2 returns irq[c] in bit 0.
- R9: Request word t sits at address 4+t. A write from the other processor stores the written value. A write from processor t clears the bits written as 1.
- R10: An active-low synchronous reset frees the lock, clears both request words and drops both interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 2 | Access strobe per processor |
| bus_wr | input | 2 | Write enable per processor |
| bus_addr | input | 2x3 | Word address per processor |
| bus_wdata | input | 2x32 | Write data per processor |
| bus_rdata | output | 2x32 | Combinational read data per processor |
| irq | output | 2 | Doorbell interrupt per processor |

## Verification
Lock writes are tried in several patterns, and each one separates a different rule:
- A claim while the lock is free.
- A competing claim while it is held.
- A release from the non-owner, then one from the owner.
- Simultaneous claims from both sides, which exposes the tie priority.
- A tag word with junk in its upper bits, which shows that only bits 1:0 are decoded and that the upper readback is zero.

Doorbells are rung one at a time, from both sides together, and while the lock is held, which shows that they route to the opposite processor and leave the owner alone. Request words get a store from the other processor and then a partial clear from their target, which tells the two write semantics apart.

// File: rtl/dual_cpu_lock_bell_pkg.sv
package dual_cpu_lock_bell_pkg;

    localparam int NCPU     = 2;
    localparam int DATA_W   = 32;
    localparam int OFS_LOCK = 0;
    localparam int OFS_RING = 1;
    localparam int OFS_ACK  = 2;
    localparam int OFS_REQ  = 4;

    // encoding equals the owner field read back by software
    typedef enum logic [1:0] {
        LK_FREE = 2'd0,
        LK_CPU0 = 2'd1,
        LK_CPU1 = 2'd2
    } lock_state_e;

    typedef enum logic {
        BELL_IDLE = 1'b0,
        BELL_PEND = 1'b1
    } bell_state_e;

endpackage

// File: rtl/dcl_lock_fsm.sv
module dcl_lock_fsm
    import dual_cpu_lock_bell_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCPU-1:0]   tag_wr,
    input  logic [NCPU-1:0]   rel_wr,
    output logic [1:0]        owner
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_FREE: begin
                if (tag_wr[0])      state_d = LK_CPU0;
                else if (tag_wr[1]) state_d = LK_CPU1;
            end
            LK_CPU0: if (rel_wr[0]) state_d = LK_FREE;
            LK_CPU1: if (rel_wr[1]) state_d = LK_FREE;
            default:                state_d = LK_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        owner = state_q;
    end

endmodule

// File: rtl/dcl_bell.sv
module dcl_bell
    import dual_cpu_lock_bell_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ring,
    input  logic ack,
    output logic pend
);

    bell_state_e state_q;
    bell_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BELL_IDLE: if (ring)        state_d = BELL_PEND;
            BELL_PEND: if (ack && !ring) state_d = BELL_IDLE;
            default:                    state_d = BELL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BELL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pend = (state_q == BELL_PEND);
    end

endmodule

// File: rtl/dcl_req_word.sv
module dcl_req_word
    import dual_cpu_lock_bell_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              store_wr,
    input  logic [DATA_W-1:0] store_data,
    input  logic              clr_wr,
    input  logic [DATA_W-1:0] clr_mask,
    output logic [DATA_W-1:0] word
);

    logic [DATA_W-1:0] word_d;

    always_comb begin
        word_d = store_wr ? store_data : word;
        if (clr_wr) word_d = word_d & ~clr_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else        word <= word_d;
    end

endmodule

// File: rtl/dual_cpu_lock_bell.sv
module dual_cpu_lock_bell
    import dual_cpu_lock_bell_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCPU-1:0]               bus_sel,
    input  logic [NCPU-1:0]               bus_wr,
    input  logic [NCPU-1:0][ADDR_W-1:0]   bus_addr,
    input  logic [NCPU-1:0][DATA_W-1:0]   bus_wdata,
    output logic [NCPU-1:0][DATA_W-1:0]   bus_rdata,
    output logic [NCPU-1:0]               irq
);

    localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);
    localparam logic [ADDR_W-1:0] A_RING = ADDR_W'(OFS_RING);
    localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);

    logic [NCPU-1:0]             tag_wr;
    logic [NCPU-1:0]             rel_wr;
    logic [NCPU-1:0]             ring_wr;
    logic [NCPU-1:0]             ack_wr;
    logic [NCPU-1:0]             req_wr_own;
    logic [NCPU-1:0]             req_wr_other;
    logic [NCPU-1:0][DATA_W-1:0] req_word;
    logic [1:0]                  owner_q;

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        localparam logic [ADDR_W-1:0] A_REQ_OWN   = ADDR_W'(OFS_REQ + c);
        localparam logic [ADDR_W-1:0] A_REQ_OTHER = ADDR_W'(OFS_REQ + (NCPU-1-c));
        localparam logic [1:0]        OWN_TAG     = 2'(c + 1);
        logic wacc;

        always_comb begin
            wacc            = bus_sel[c] && bus_wr[c];
            tag_wr[c]       = wacc && (bus_addr[c] == A_LOCK) && (bus_wdata[c][1:0] == OWN_TAG);
            rel_wr[c]       = wacc && (bus_addr[c] == A_LOCK) && (bus_wdata[c][1:0] == 2'd0);
            ring_wr[c]      = wacc && (bus_addr[c] == A_RING) && bus_wdata[c][0];
            ack_wr[c]       = wacc && (bus_addr[c] == A_ACK)  && bus_wdata[c][0];
            req_wr_own[c]   = wacc && (bus_addr[c] == A_REQ_OWN);
            req_wr_other[c] = wacc && (bus_addr[c] == A_REQ_OTHER);
        end

        // the bell of processor c is rung by the other processor
        dcl_bell u_bell (
            .clk  (clk),
            .rst_n(rst_n),
            .ring (ring_wr[NCPU-1-c]),
            .ack  (ack_wr[c]),
            .pend (irq[c])
        );

        // request word targeting processor c
        dcl_req_word u_req (
            .clk       (clk),
            .rst_n     (rst_n),
            .store_wr  (req_wr_other[NCPU-1-c]),
            .store_data(bus_wdata[NCPU-1-c]),
            .clr_wr    (req_wr_own[c]),
            .clr_mask  (bus_wdata[c]),
            .word      (req_word[c])
        );

        always_comb begin
            bus_rdata[c] = '0;
            case (bus_addr[c])
                A_LOCK:      bus_rdata[c] = {{(DATA_W-2){1'b0}}, owner_q};
                A_ACK:       bus_rdata[c] = {{(DATA_W-1){1'b0}}, irq[c]};
                A_REQ_OWN:   bus_rdata[c] = req_word[c];
                A_REQ_OTHER: bus_rdata[c] = req_word[NCPU-1-c];
                default:     bus_rdata[c] = '0;
            endcase
        end
    end

    dcl_lock_fsm u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .tag_wr(tag_wr),
        .rel_wr(rel_wr),
        .owner (owner_q)
    );

endmodule

// File: rtl/dual_cpu_lock_bell_chk.sv
module dual_cpu_lock_bell_chk
    import dual_cpu_lock_bell_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NCPU-1:0]             bus_sel,
    input logic [NCPU-1:0]             bus_wr,
    input logic [NCPU-1:0][ADDR_W-1:0] bus_addr,
    input logic [NCPU-1:0][DATA_W-1:0] bus_wdata,
    input logic [NCPU-1:0][DATA_W-1:0] bus_rdata,
    input logic [NCPU-1:0]             irq,
    input logic [1:0]                  owner
);

    logic [NCPU-1:0] lk_w, rg_w, ak_w;
    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            lk_w[c] = bus_sel[c] && bus_wr[c] && (bus_addr[c] == ADDR_W'(OFS_LOCK));
            rg_w[c] = bus_sel[c] && bus_wr[c] && (bus_addr[c] == ADDR_W'(OFS_RING)) && bus_wdata[c][0];
            ak_w[c] = bus_sel[c] && bus_wr[c] && (bus_addr[c] == ADDR_W'(OFS_ACK)) && bus_wdata[c][0];
        end
    end

    // R1
    lock_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[0] == ADDR_W'(OFS_LOCK)) |-> (bus_rdata[0][DATA_W-1:2] == '0));

    // R3
    held0_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == 2'd1 && !(lk_w[0] && bus_wdata[0][1:0] == 2'd0)) |=> (owner == 2'd1));

    // R5
    held1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == 2'd2 && !(lk_w[1] && bus_wdata[1][1:0] == 2'd0)) |=> (owner == 2'd2));

    // R6
    tie_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == 2'd0 && lk_w[0] && bus_wdata[0][1:0] == 2'd1
         && lk_w[1] && bus_wdata[1][1:0] == 2'd2) |=> (owner == 2'd1));

    // R7
    ring_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rg_w[0] |=> irq[1]);

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[0] && !ak_w[0]) |=> irq[0]);

    // R7
    ring_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_w[1] && lk_w == '0) |=> $stable(owner));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (owner == 2'd0 && irq == '0));

endmodule

bind dual_cpu_lock_bell dual_cpu_lock_bell_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .owner    (owner_q)
);

// File: tb/sim_dual_cpu_lock_bell.sv
module sim_dual_cpu_lock_bell;

    localparam int AW = 3;
    localparam int NV = 15;

    typedef struct packed {
        logic        w0;
        logic [2:0]  a0;
        logic [31:0] d0;
        logic        w1;
        logic [2:0]  a1;
        logic [31:0] d1;
        logic        rc;
        logic [2:0]  ra;
        logic [31:0] exp;
        logic [1:0]  irqx;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd0, 32'd1,          1'b0, 3'd0, 32'd0,          1'b0, 3'd0, 32'd1,          2'b00},
        '{1'b0, 3'd0, 32'd0,          1'b1, 3'd0, 32'd2,          1'b1, 3'd0, 32'd1,          2'b00},
        '{1'b0, 3'd0, 32'd0,          1'b1, 3'd0, 32'd0,          1'b1, 3'd0, 32'd1,          2'b00},
        '{1'b1, 3'd0, 32'd0,          1'b0, 3'd0, 32'd0,          1'b0, 3'd0, 32'd0,          2'b00},
        '{1'b0, 3'd0, 32'd0,          1'b1, 3'd0, 32'd2,          1'b1, 3'd0, 32'd2,          2'b00},
        '{1'b0, 3'd0, 32'd0,          1'b1, 3'd1, 32'd1,          1'b0, 3'd0, 32'd2,          2'b01},
        '{1'b1, 3'd5, 32'h8000_0001,  1'b0, 3'd0, 32'd0,          1'b1, 3'd5, 32'h8000_0001,  2'b01},
        '{1'b0, 3'd0, 32'd0,          1'b1, 3'd5, 32'h0000_0001,  1'b0, 3'd5, 32'h8000_0000,  2'b01},
        '{1'b1, 3'd2, 32'd1,          1'b0, 3'd0, 32'd0,          1'b0, 3'd2, 32'd0,          2'b00},
        '{1'b0, 3'd0, 32'd0,          1'b1, 3'd0, 32'd0,          1'b1, 3'd0, 32'd0,          2'b00},
        '{1'b1, 3'd0, 32'd1,          1'b1, 3'd0, 32'd2,          1'b1, 3'd0, 32'd1,          2'b00},
        '{1'b1, 3'd1, 32'd1,          1'b0, 3'd0, 32'd0,          1'b1, 3'd2, 32'd1,          2'b10},
        '{1'b0, 3'd0, 32'd0,          1'b1, 3'd2, 32'd1,          1'b0, 3'd0, 32'd1,          2'b00},
        '{1'b1, 3'd1, 32'd1,          1'b1, 3'd1, 32'd1,          1'b0, 3'd2, 32'd1,          2'b11},
        '{1'b1, 3'd0, 32'd0,          1'b0, 3'd0, 32'd0,          1'b0, 3'd0, 32'd0,          2'b11}
    };

    function automatic string req_of(int i);
        case (i)
            0: return "R2";   1: return "R3";   2: return "R5";
            3: return "R4";   4: return "R2";   5: return "R7";
            6: return "R9";   7: return "R9";   8: return "R8";
            9: return "R4";  10: return "R6";  11: return "R7";
            12: return "R8"; 13: return "R7";  default: return "R4";
        endcase
    endfunction

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [1:0]            bus_sel = '0;
    logic [1:0]            bus_wr = '0;
    logic [1:0][AW-1:0]    bus_addr = '0;
    logic [1:0][31:0]      bus_wdata = '0;
    logic [1:0][31:0]      bus_rdata;
    logic [1:0]            irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dual_cpu_lock_bell #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(int c, logic [2:0] a);
        bus_sel = '0; bus_wr = '0;
        bus_addr[c] = a;
        #1;
    endtask

    task automatic wr(int c, logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = '0; bus_wr = '0;
        bus_sel[c] = 1'b1; bus_wr[c] = 1'b1; bus_addr[c] = a; bus_wdata[c] = d;
        @(posedge clk); #2;
        bus_sel = '0; bus_wr = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R10 and R1: reset state
        rd(0, 3'd0); check("R10", bus_rdata[0], 32'd0);
        check("R10", {30'd0, irq}, 32'd0);
        rd(1, 3'd4); check("R10", bus_rdata[1], 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_sel = {VEC[i].w1, VEC[i].w0};
            bus_wr  = {VEC[i].w1, VEC[i].w0};
            bus_addr[0] = VEC[i].a0; bus_wdata[0] = VEC[i].d0;
            bus_addr[1] = VEC[i].a1; bus_wdata[1] = VEC[i].d1;
            @(posedge clk); #2;
            rd(int'(VEC[i].rc), VEC[i].ra);
            check(req_of(i), bus_rdata[VEC[i].rc], VEC[i].exp);
            check(req_of(i), {30'd0, irq}, {30'd0, VEC[i].irqx});
        end

        // R1: upper write bits ignored, upper read bits zero
        wr(1, 3'd2, 32'd1);
        wr(0, 3'd2, 32'd1);
        wr(0, 3'd0, 32'hFFFF_FFF1);
        rd(1, 3'd0); check("R1", bus_rdata[1], 32'd1);
        // R2: wrong tag from processor 1 while free does nothing
        wr(0, 3'd0, 32'd0);
        wr(1, 3'd0, 32'd1);
        rd(1, 3'd0); check("R2", bus_rdata[1], 32'd0);
        // R8: ring and ack in the same cycle leaves irq raised
        @(negedge clk);
        bus_sel = 2'b11; bus_wr = 2'b11;
        bus_addr[0] = 3'd1; bus_wdata[0] = 32'd1;
        bus_addr[1] = 3'd2; bus_wdata[1] = 32'd1;
        @(posedge clk); #2;
        rd(1, 3'd2); check("R8", bus_rdata[1], 32'd1);
        // R10: reset mid-operation clears everything
        wr(0, 3'd4 + 3'd1, 32'h0000_00F0);
        wr(1, 3'd0, 32'd2);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2; rst_n = 1'b1;
        rd(0, 3'd0); check("R10", bus_rdata[0], 32'd0);
        rd(0, 3'd5); check("R10", bus_rdata[0], 32'd0);
        check("R10", {30'd0, irq}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule